// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sits beside the core of an 8-bit microcontroller. It runs from the raw oscillator clock and decides when the core and its peripherals get clock enables. It filters the external reset pin into a clean system reset. That reset is raised only after the pin has been held high for a set number of machine cycles, and one machine cycle is twelve oscillator periods by default. The internal clock phase comes from a divide-by-two stage. The CPU enable and the peripheral enable are two gated copies of that phase.

Software asks for a low-power mode through two register bits, light sleep and deep sleep. When both bits are set, deep sleep wins. In light sleep the CPU enable stops, while the peripheral enable keeps toggling so that timers, the serial channel and interrupt logic keep working. An enabled pending interrupt ends light sleep. It does so through a one-cycle wake state that pulses a request-clear strobe back to the mode register. In deep sleep the block raises an oscillator-stop output and freezes both enables. Only a system reset leaves deep sleep.

While either mode is active, the block drives override controls for the address-latch strobe, the program-store strobe and two ports. What it drives depends on whether code runs from external program memory. If the reset pin is seen while the part is in light sleep, the CPU clock resumes before the reset has been qualified. In that window the block raises a RAM-write block. Port writes are not affected by it.

Top module: `pmc_ctrl`

## Requirements
- R1: `sys_rst_o` goes high after `rst_pin_i` has been seen high, through a two-flop synchroniser, on 24 consecutive clocks (two machine cycles of 12). With the pin raised before edge 1, `sys_rst_o` is high after edge 26 and not before. It falls on the second edge after the pin goes low.
- R2: Outside reset and deep sleep, `per_ce_o` is high on alternate clocks (divide by two). During reset, `cpu_ce_o` and `per_ce_o` are both low.
- R3: A request seen at a clock edge in the running state enters its mode at that edge. If both bits are set, deep sleep is chosen. Requests are ignored while the synchronised reset pin is high.
- R4: In light sleep, `cpu_ce_o` stays low and `per_ce_o` keeps toggling.
- R5: `irq_pend_i` high at an edge in light sleep moves the block to a wake state for one cycle. In that cycle `req_clr_o` is 1 and `cpu_ce_o` follows the phase. The block then returns to running.
- R6: In deep sleep, `osc_stop_o` is 1 and both enables are 0. `irq_pend_i` has no effect, and only `sys_rst_o` leaves the state.
- R7: In light sleep, `ale_force_o` and `psen_force_o` are 1 with the levels 1. In deep sleep, both forces are 1 with the levels 0. While running, both forces are 0.
- R8: `p0_float_o` is 1 in either mode when `ext_exec_i` is 1. `p2_addr_o` is 1 only in light sleep with `ext_exec_i` at 1.
- R9: If the synchronised reset pin is seen in light sleep, the next edge returns the block to running with `ram_wr_blk_o` at 1. That output stays high until `sys_rst_o` or until the synchronised pin falls.
- R10: `sys_rst_o` returns the block to running from any state and clears `ram_wr_blk_o` and `osc_stop_o` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Raw oscillator clock |
| rst_pin_i | input | 1 | External reset pin, active high, asynchronous |
| idl_req_i | input | 1 | Light-sleep request bit from the mode register |
| pd_req_i | input | 1 | Deep-sleep request bit from the mode register |
| irq_pend_i | input | 1 | Enabled interrupt pending |
| ext_exec_i | input | 1 | Code executes from external program memory |
| sys_rst_o | output | 1 | Qualified system reset |
| cpu_ce_o | output | 1 | CPU clock enable |
| per_ce_o | output | 1 | Peripheral clock enable |
| osc_stop_o | output | 1 | Oscillator stop request |
| req_clr_o | output | 1 | Clears both mode request bits on wake |
| ram_wr_blk_o | output | 1 | Blocks internal RAM writes |
| ale_force_o | output | 1 | Address-latch strobe override active |
| ale_level_o | output | 1 | Forced address-latch strobe level |
| psen_force_o | output | 1 | Program-store strobe override active |
| psen_level_o | output | 1 | Forced program-store strobe level |
| p0_float_o | output | 1 | Port 0 to high impedance |
| p2_addr_o | output | 1 | Port 2 drives the address byte, not its latch |

## Verification
The assertions check on every cycle that the outputs stay consistent with each other. Deep sleep keeps both enables low and persists. The two strobe overrides agree, and a port-2 address drive always comes with a floating port 0. The wake strobe lasts exactly one cycle, the peripheral enable never holds high twice in a row, and a reset returns the block to running. Only the bench's scenarios can show the exact reset qualification count, the choice between simultaneous requests, the requests ignored while the reset pin is high, and the length of the RAM-write block window. The bench does this by comparing every output against a behavioural model on every clock.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_IDLE = 2'd1,
      PM_WAKE = 2'd2,
      PM_DOWN = 2'd3
   } pm_state_t;
endpackage

// File: rtl/pmc_rst_filter.sv
module pmc_rst_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int MC_OSC      = 12,
   parameter int RST_MC      = 2
) (
   input  logic clk_i,
   input  logic pin_i,
   output logic pin_seen_o,
   output logic sys_rst_o
);
   localparam int RST_CYC = MC_OSC * RST_MC;
   localparam int CW      = $clog2(RST_CYC + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pmc_rst_filter: SYNC_STAGES must be at least 2");
      end
      if (RST_MC < 1) begin : g_bad_mc
         $error("pmc_rst_filter: RST_MC must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CW-1:0]          hi_cnt_q;

   always_ff @(posedge clk_i) begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
   end

   assign pin_seen_o = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk_i) begin
      if (!pin_seen_o) begin
         hi_cnt_q <= '0;
      end else if (hi_cnt_q != CW'(RST_CYC)) begin
         hi_cnt_q <= hi_cnt_q + CW'(1);
      end
   end

   assign sys_rst_o = pin_seen_o && (hi_cnt_q == CW'(RST_CYC));
endmodule

// File: rtl/pmc_clk_div.sv
module pmc_clk_div #(
   parameter int DIV = 2
) (
   input  logic clk_i,
   input  logic sys_rst_i,
   input  logic hold_i,
   output logic phase_o
);
   localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("pmc_clk_div: DIV must be at least 2");
      end
      if (DIV == 2) begin : g_toggle
         logic ph_q;
         always_ff @(posedge clk_i) begin
            if (sys_rst_i)    ph_q <= 1'b0;
            else if (!hold_i) ph_q <= ~ph_q;
         end
         assign phase_o = ph_q;
      end else begin : g_count
         logic [PW-1:0] cnt_q;
         always_ff @(posedge clk_i) begin
            if (sys_rst_i)                      cnt_q <= '0;
            else if (!hold_i) begin
               if (cnt_q == PW'(DIV - 1))       cnt_q <= '0;
               else                             cnt_q <= cnt_q + PW'(1);
            end
         end
         assign phase_o = (cnt_q == PW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
   import pmc_pkg::*;
(
   input  logic      clk_i,
   input  logic      sys_rst_i,
   input  logic      pin_seen_i,
   input  logic      idl_req_i,
   input  logic      pd_req_i,
   input  logic      irq_i,
   output pm_state_t state_o,
   output logic      blk_o
);
   pm_state_t st_q, st_d;
   logic      blk_q, blk_d;

   always_comb begin
      st_d  = st_q;
      blk_d = blk_q;
      unique case (st_q)
         PM_RUN: begin
            if (!pin_seen_i) begin
               if (pd_req_i)       st_d = PM_DOWN;
               else if (idl_req_i) st_d = PM_IDLE;
            end
         end
         PM_IDLE: begin
            if (pin_seen_i) begin
               st_d  = PM_RUN;
               blk_d = 1'b1;
            end else if (irq_i) begin
               st_d = PM_WAKE;
            end
         end
         PM_WAKE: st_d = PM_RUN;
         PM_DOWN: st_d = PM_DOWN;
         default: st_d = PM_RUN;
      endcase
      if (!pin_seen_i) blk_d = 1'b0;
   end

   always_ff @(posedge clk_i) begin
      if (sys_rst_i) begin
         st_q  <= PM_RUN;
         blk_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         blk_q <= blk_d;
      end
   end

   assign state_o = st_q;
   assign blk_o   = blk_q;
endmodule

// File: rtl/pmc_pin_ovr.sv
module pmc_pin_ovr
   import pmc_pkg::*;
#(
   parameter bit PIN_REG = 1'b0
) (
   input  logic      clk_i,
   input  logic      sys_rst_i,
   input  pm_state_t state_i,
   input  logic      ext_i,
   output logic      force_o,
   output logic      level_o,
   output logic      p0_float_o,
   output logic      p2_addr_o
);
   logic [3:0] ovr_d;
   logic       low_pwr;

   assign low_pwr = (state_i == PM_IDLE) || (state_i == PM_DOWN);
   assign ovr_d   = {low_pwr,
                     state_i == PM_IDLE,
                     low_pwr && ext_i,
                     (state_i == PM_IDLE) && ext_i};

   generate
      if (PIN_REG) begin : g_reg
         logic [3:0] ovr_q;
         always_ff @(posedge clk_i) begin
            if (sys_rst_i) ovr_q <= '0;
            else           ovr_q <= ovr_d;
         end
         assign {force_o, level_o, p0_float_o, p2_addr_o} = ovr_q;
      end else begin : g_comb
         assign {force_o, level_o, p0_float_o, p2_addr_o} = ovr_d;
      end
   endgenerate
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
   import pmc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MC_OSC      = 12,
   parameter int RST_MC      = 2,
   parameter int CLK_DIV     = 2,
   parameter bit PIN_REG     = 1'b0
) (
   input  logic osc_clk_i,
   input  logic rst_pin_i,
   input  logic idl_req_i,
   input  logic pd_req_i,
   input  logic irq_pend_i,
   input  logic ext_exec_i,
   output logic sys_rst_o,
   output logic cpu_ce_o,
   output logic per_ce_o,
   output logic osc_stop_o,
   output logic req_clr_o,
   output logic ram_wr_blk_o,
   output logic ale_force_o,
   output logic ale_level_o,
   output logic psen_force_o,
   output logic psen_level_o,
   output logic p0_float_o,
   output logic p2_addr_o
);
   generate
      if (MC_OSC % CLK_DIV != 0) begin : g_bad_ratio
         $error("pmc_ctrl: MC_OSC must be a multiple of CLK_DIV");
      end
   endgenerate

   logic      pin_seen;
   logic      phase;
   logic      frz;
   logic      strobe_force;
   logic      strobe_level;
   pm_state_t state;

   pmc_rst_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .MC_OSC      (MC_OSC),
      .RST_MC      (RST_MC)
   ) u_rst (
      .clk_i      (osc_clk_i),
      .pin_i      (rst_pin_i),
      .pin_seen_o (pin_seen),
      .sys_rst_o  (sys_rst_o)
   );

   pmc_mode_fsm u_fsm (
      .clk_i      (osc_clk_i),
      .sys_rst_i  (sys_rst_o),
      .pin_seen_i (pin_seen),
      .idl_req_i  (idl_req_i),
      .pd_req_i   (pd_req_i),
      .irq_i      (irq_pend_i),
      .state_o    (state),
      .blk_o      (ram_wr_blk_o)
   );

   assign frz = (state == PM_DOWN);

   pmc_clk_div #(
      .DIV (CLK_DIV)
   ) u_div (
      .clk_i     (osc_clk_i),
      .sys_rst_i (sys_rst_o),
      .hold_i    (frz),
      .phase_o   (phase)
   );

   assign osc_stop_o = frz;
   assign req_clr_o  = (state == PM_WAKE);
   assign per_ce_o   = phase && !sys_rst_o && !frz;
   assign cpu_ce_o   = phase && !sys_rst_o &&
                       ((state == PM_RUN) || (state == PM_WAKE));

   pmc_pin_ovr #(
      .PIN_REG (PIN_REG)
   ) u_ovr (
      .clk_i      (osc_clk_i),
      .sys_rst_i  (sys_rst_o),
      .state_i    (state),
      .ext_i      (ext_exec_i),
      .force_o    (strobe_force),
      .level_o    (strobe_level),
      .p0_float_o (p0_float_o),
      .p2_addr_o  (p2_addr_o)
   );

   assign ale_force_o  = strobe_force;
   assign ale_level_o  = strobe_level;
   assign psen_force_o = strobe_force;
   assign psen_level_o = strobe_level;
endmodule

// File: rtl/pmc_ctrl_chk.sv
module pmc_ctrl_chk (
   input logic osc_clk_i,
   input logic rst_pin_i,
   input logic irq_pend_i,
   input logic sys_rst_o,
   input logic cpu_ce_o,
   input logic per_ce_o,
   input logic osc_stop_o,
   input logic req_clr_o,
   input logic ram_wr_blk_o,
   input logic ale_force_o,
   input logic ale_level_o,
   input logic psen_force_o,
   input logic psen_level_o,
   input logic p0_float_o,
   input logic p2_addr_o
);
   // R1: a qualified reset needs the pin high two clocks earlier
   assert_rst_from_pin_R1: assert property (@(posedge osc_clk_i) disable iff (!rst_pin_i)
      sys_rst_o |-> $past(rst_pin_i, 2));

   // R2: the divided phase never stays high on two edges in a row
   assert_per_div_R2: assert property (@(posedge osc_clk_i) disable iff (sys_rst_o)
      per_ce_o |=> !per_ce_o);

   // R4: strobes forced high (light sleep) imply a stopped CPU
   assert_idle_cpu_R4: assert property (@(posedge osc_clk_i) disable iff (sys_rst_o)
      (ale_force_o && ale_level_o) |-> !cpu_ce_o);

   // R5: wake strobe lasts exactly one cycle
   assert_clr_pulse_R5: assert property (@(posedge osc_clk_i) disable iff (sys_rst_o)
      req_clr_o |=> !req_clr_o);

   // R6: deep sleep freezes both enables
   assert_down_frozen_R6: assert property (@(posedge osc_clk_i) disable iff (sys_rst_o)
      osc_stop_o |-> (!cpu_ce_o && !per_ce_o));

   // R6: deep sleep persists until reset, whatever the interrupt input does
   assert_down_sticky_R6: assert property (@(posedge osc_clk_i) disable iff (sys_rst_o)
      osc_stop_o |=> osc_stop_o);

   // R7: both strobe overrides agree
   assert_strobes_match_R7: assert property (@(posedge osc_clk_i) disable iff (sys_rst_o)
      ale_force_o |-> (psen_force_o && (ale_level_o == psen_level_o)));

   // R7: strobes forced low only in deep sleep
   assert_low_strobe_down_R7: assert property (@(posedge osc_clk_i) disable iff (sys_rst_o)
      (ale_force_o && !ale_level_o) |-> osc_stop_o);

   // R8: port 2 address drive only with port 0 floating
   assert_p2_needs_p0_R8: assert property (@(posedge osc_clk_i) disable iff (sys_rst_o)
      p2_addr_o |-> p0_float_o);

   // R10: reset leaves the block running with no RAM-write block
   assert_rst_exit_R10: assert property (@(posedge osc_clk_i) disable iff (!rst_pin_i)
      sys_rst_o |=> (!osc_stop_o && !ram_wr_blk_o && !ale_force_o));
endmodule

bind pmc_ctrl pmc_ctrl_chk u_chk (
   .osc_clk_i    (osc_clk_i),
   .rst_pin_i    (rst_pin_i),
   .irq_pend_i   (irq_pend_i),
   .sys_rst_o    (sys_rst_o),
   .cpu_ce_o     (cpu_ce_o),
   .per_ce_o     (per_ce_o),
   .osc_stop_o   (osc_stop_o),
   .req_clr_o    (req_clr_o),
   .ram_wr_blk_o (ram_wr_blk_o),
   .ale_force_o  (ale_force_o),
   .ale_level_o  (ale_level_o),
   .psen_force_o (psen_force_o),
   .psen_level_o (psen_level_o),
   .p0_float_o   (p0_float_o),
   .p2_addr_o    (p2_addr_o)
);

// File: tb/sim_pmc_ctrl.sv
`timescale 1ns/1ps
module sim_pmc_ctrl;
   localparam int RSTC = 24;

   logic clk = 1'b0;
   logic rst_pin = 1'b0, idl_req = 1'b0, pd_req = 1'b0, irq = 1'b0, ext = 1'b0;
   logic sys_rst, cpu_ce, per_ce, osc_stop, req_clr, ram_blk;
   logic ale_f, ale_l, psen_f, psen_l, p0_fl, p2_ad;

   int errs = 0;
   int checks = 0;
   bit cmp_on = 1'b0;

   always #4 clk = ~clk;

   pmc_ctrl u0 (
      .osc_clk_i (clk), .rst_pin_i (rst_pin), .idl_req_i (idl_req),
      .pd_req_i (pd_req), .irq_pend_i (irq), .ext_exec_i (ext),
      .sys_rst_o (sys_rst), .cpu_ce_o (cpu_ce), .per_ce_o (per_ce),
      .osc_stop_o (osc_stop), .req_clr_o (req_clr), .ram_wr_blk_o (ram_blk),
      .ale_force_o (ale_f), .ale_level_o (ale_l), .psen_force_o (psen_f),
      .psen_level_o (psen_l), .p0_float_o (p0_fl), .p2_addr_o (p2_ad)
   );

   // behavioural reference: mode 0 run, 1 light sleep, 2 wake, 3 deep sleep
   bit m_s1 = 0, m_s2 = 0, m_half = 0, m_blk = 0;
   int m_run = 0, m_mode = 0;

   function automatic bit m_rst();
      return m_s2 && (m_run == RSTC);
   endfunction

   always @(posedge clk) begin
      bit o_s2, o_rst;
      int o_mode;
      o_s2 = m_s2; o_rst = m_rst(); o_mode = m_mode;
      if (o_rst) begin
         m_mode = 0; m_blk = 0; m_half = 0;
      end else begin
         if (o_mode == 0 && !o_s2) m_mode = pd_req ? 3 : (idl_req ? 1 : 0);
         else if (o_mode == 1 && o_s2) begin m_mode = 0; m_blk = 1; end
         else if (o_mode == 1 && irq) m_mode = 2;
         else if (o_mode == 2) m_mode = 0;
         if (!o_s2) m_blk = 0;
         if (o_mode != 3) m_half = !m_half;
      end
      if (!o_s2) m_run = 0;
      else if (m_run < RSTC) m_run++;
      m_s2 = m_s1;
      m_s1 = rst_pin;
   end

   task automatic chk(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (cmp_on) begin
         bit r, lp;
         r  = m_rst();
         lp = (m_mode == 1) || (m_mode == 3);
         chk("R1", "sys_rst", sys_rst, r);
         chk("R2", "per_ce", per_ce, m_half && !r && m_mode != 3);
         chk("R4", "cpu_ce", cpu_ce, m_half && !r && (m_mode == 0 || m_mode == 2));
         chk("R6", "osc_stop", osc_stop, m_mode == 3);
         chk("R5", "req_clr", req_clr, m_mode == 2);
         chk("R9", "ram_blk", ram_blk, m_blk);
         chk("R7", "ale_force", ale_f, lp);
         chk("R7", "ale_level", ale_l, m_mode == 1);
         chk("R7", "psen_force", psen_f, lp);
         chk("R7", "psen_level", psen_l, m_mode == 1);
         chk("R8", "p0_float", p0_fl, lp && ext);
         chk("R8", "p2_addr", p2_ad, (m_mode == 1) && ext);
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic full_reset();
      rst_pin = 1'b1;
      step(RSTC + 6);
      idl_req = 1'b0; pd_req = 1'b0; irq = 1'b0;
      rst_pin = 1'b0;
      step(4);
   endtask

   task automatic run_all();
      bit prev;
      step(4);
      cmp_on = 1'b1;
      // R1: qualification count, pin raised before edge 1
      rst_pin = 1'b1;
      step(25);
      chk("R1", "reset not yet at edge 25", sys_rst, 1'b0);
      step(1);
      chk("R1", "reset at edge 26", sys_rst, 1'b1);
      step(6);
      chk("R2", "cpu_ce low in reset", cpu_ce, 1'b0);
      chk("R2", "per_ce low in reset", per_ce, 1'b0);
      rst_pin = 1'b0;
      step(1);
      chk("R1", "reset held one edge after pin low", sys_rst, 1'b1);
      step(1);
      chk("R1", "reset released", sys_rst, 1'b0);
      step(3);
      prev = per_ce;
      step(1);
      chk("R2", "per_ce alternates", per_ce, !prev);

      // R4/R5/R7/R8: light sleep with external code, wake by interrupt
      ext = 1'b1;
      idl_req = 1'b1;
      step(1);
      chk("R7", "ale forced high in light sleep", ale_f && ale_l, 1'b1);
      chk("R8", "p2 address in light sleep ext", p2_ad, 1'b1);
      for (int i = 0; i < 4; i++) begin
         step(1);
         chk("R4", "cpu_ce stopped in light sleep", cpu_ce, 1'b0);
      end
      irq = 1'b1;
      step(1);
      chk("R5", "clear strobe on wake", req_clr, 1'b1);
      irq = 1'b0; idl_req = 1'b0;
      step(1);
      chk("R5", "clear strobe one cycle", req_clr, 1'b0);
      chk("R7", "no override when running", ale_f, 1'b0);

      // R3/R6/R7/R8: both bits set, deep sleep wins; interrupt ignored
      idl_req = 1'b1; pd_req = 1'b1;
      step(1);
      chk("R3", "deep sleep chosen over light", osc_stop, 1'b1);
      chk("R7", "ale forced low in deep sleep", ale_f && !ale_l, 1'b1);
      chk("R8", "p0 floats in deep sleep ext", p0_fl, 1'b1);
      chk("R8", "p2 keeps data in deep sleep", p2_ad, 1'b0);
      irq = 1'b1;
      step(5);
      chk("R6", "interrupt ignored in deep sleep", osc_stop, 1'b1);
      chk("R6", "enables frozen", per_ce || cpu_ce, 1'b0);
      irq = 1'b0;
      ext = 1'b0;
      rst_pin = 1'b1;
      step(RSTC + 6);
      idl_req = 1'b0; pd_req = 1'b0;
      rst_pin = 1'b0;
      step(4);
      chk("R10", "reset leaves deep sleep", osc_stop, 1'b0);

      // R3: request ignored while the reset pin is seen high
      rst_pin = 1'b1;
      step(3);
      idl_req = 1'b1;
      step(4);
      chk("R3", "request ignored during reset pin", ale_f, 1'b0);
      rst_pin = 1'b0;
      step(3);
      chk("R3", "light sleep after pin drops", ale_f && ale_l, 1'b1);
      chk("R8", "p0 holds data internal code", p0_fl, 1'b0);

      // R9: reset pin during light sleep
      rst_pin = 1'b1;
      step(3);
      chk("R9", "RAM write block raised", ram_blk, 1'b1);
      chk("R9", "override released", ale_f, 1'b0);
      step(10);
      chk("R9", "RAM write block held", ram_blk, 1'b1);
      step(RSTC);
      idl_req = 1'b0;
      chk("R10", "RAM write block cleared by reset", ram_blk, 1'b0);
      rst_pin = 1'b0;
      step(4);

      // R9: short pin pulse in light sleep drops the block when pin falls
      idl_req = 1'b1;
      step(2);
      rst_pin = 1'b1;
      step(4);
      rst_pin = 1'b0;
      step(3);
      chk("R9", "block drops with pin", ram_blk, 1'b0);
      idl_req = 1'b0;
      full_reset();
      step(4);
   endtask

   initial begin
      fork
         run_all();
         begin
            step(100000);
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      cmp_on = 1'b0;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule